// File: doc/BRIEF.md
# Configurable Product-Term Sum Logic

This block is the combinational front end of one cell in a programmable logic array. Five product terms are formed from a shared input bus. Each term is an AND over the bus bits that its configuration selects, with each selected bit taken in true or complemented form. A static configuration then sends each term to one of three places: the local OR sum, the second input of the XOR stage, or a dedicated control output. A term can also be left unused.

The local sum is ORed with a cascade sum arriving from a neighbouring cell. The result is passed on as the cascade output, so chained cells can build wide sum-of-products terms. The same value then enters an XOR stage. The second XOR input is a constant 0, a constant 1 (which inverts the output) or one chosen product term.

A separate foldback output carries the inverse of one chosen product term, for use on a regional bus. All configuration arrives as parallel static inputs. The clock and active-high synchronous reset serve only to sample the embedded checks.

Top module: `pterm_cell`

## Requirements
- R1: For term t and bus bit b, the 2-bit code at `lit_cfg_i[(t*BUS_W+b)*2 +: 2]` means: 00 ignore the bit, 01 the bit must be 1, 10 the bit must be 0, 11 force the term to 0. A term is the AND of all its bit conditions.
- R2: A term whose codes are all 00 evaluates to 1 whatever the bus holds.
- R3: The route code of term t at `route_cfg_i[2*t +: 2]` is 00 for the sum, 01 for the XOR source, 10 for control and 11 for unused. The local sum is the OR of the terms routed to the sum. Any term not routed to the sum contributes 0 to it.
- R4: `casc_o` equals the local sum ORed with `casc_i`.
- R5: `xor_o` equals `casc_o` XOR a second input chosen by `xmode_i`: 00 selects 0, 01 selects 1, 10 selects the term indexed by `xidx_i`, and 11 behaves as 00.
- R6: `ctrl_o[t]` equals term t when that term is routed to control, and 0 otherwise.
- R7: `fold_o` is the inverse of the term indexed by `fold_idx_i`. When that index is 5 or more, `fold_o` is 1.
- R8: In `xmode_i` 10, the second XOR input is 0 when `xidx_i` is 5 or more, or when the indexed term is not routed to the XOR source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock for embedded checks |
| rst_i | input | 1 | Active-high synchronous reset for embedded checks |
| bus_i | input | BUS_W | Shared input bus |
| lit_cfg_i | input | 5*2*BUS_W | Per-term, per-bit literal codes |
| route_cfg_i | input | 10 | Per-term destination codes |
| xmode_i | input | 2 | XOR second-input mode |
| xidx_i | input | 3 | Term index for XOR term mode |
| fold_idx_i | input | 3 | Term index for foldback |
| casc_i | input | 1 | Cascade sum from neighbouring cell |
| casc_o | output | 1 | Cascade sum to next cell |
| xor_o | output | 1 | XOR stage output |
| ctrl_o | output | 5 | Product terms routed to control |
| fold_o | output | 1 | Inverted foldback term |

## Verification
The bench builds the cell with an 8-bit bus. With so few bits, randomly drawn literal codes that lean toward don't-care still let terms evaluate to 1 often, so sums, polarity flips and control outputs toggle in both directions. The 3-bit index inputs are drawn over their full range, which puts the out-of-range foldback and XOR-term cases within reach. Directed vectors pin down single-literal matching, the forcing code and terms that are routed away from the sum.

// File: rtl/pterm_pkg.sv
package pterm_pkg;

    localparam int NUM_PT = 5;
    localparam int IDX_W  = 3;

    typedef enum logic [1:0] {
        LIT_DC   = 2'b00,
        LIT_POS  = 2'b01,
        LIT_NEG  = 2'b10,
        LIT_KILL = 2'b11
    } lit_e;

    typedef enum logic [1:0] {
        RT_SUM  = 2'b00,
        RT_XOR  = 2'b01,
        RT_CTRL = 2'b10,
        RT_IDLE = 2'b11
    } route_e;

    typedef enum logic [1:0] {
        XS_ZERO = 2'b00,
        XS_ONE  = 2'b01,
        XS_TERM = 2'b10,
        XS_RSVD = 2'b11
    } xsel_e;

    typedef struct packed {
        logic to_sum;
        logic to_xor;
        logic to_ctrl;
    } alloc_t;

    function automatic logic lit_pass(input lit_e code, input logic bit_v);
        case (code)
            LIT_DC:   return 1'b1;
            LIT_POS:  return bit_v;
            LIT_NEG:  return ~bit_v;
            default:  return 1'b0;
        endcase
    endfunction

    function automatic alloc_t decode_route(input route_e r);
        alloc_t a;
        a = '0;
        case (r)
            RT_SUM:  a.to_sum  = 1'b1;
            RT_XOR:  a.to_xor  = 1'b1;
            RT_CTRL: a.to_ctrl = 1'b1;
            default: a = '0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/pterm_and.sv
module pterm_and
    import pterm_pkg::*;
#(
    parameter int BUS_W = 40
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [BUS_W-1:0]   bus_i,
    input  logic [2*BUS_W-1:0] lit_i,
    output logic               term_o
);

    logic [BUS_W-1:0] pass_vec;

    for (genvar b = 0; b < BUS_W; b++) begin : g_bit
        assign pass_vec[b] = lit_pass(lit_e'(lit_i[2*b +: 2]), bus_i[b]);
    end

    assign term_o = &pass_vec;

    // R2
    all_dc_true_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (lit_i == '0) |-> term_o);

endmodule

// File: rtl/pterm_route.sv
module pterm_route
    import pterm_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [NUM_PT-1:0]   terms_i,
    input  logic [2*NUM_PT-1:0] route_cfg_i,
    output logic                sum_o,
    output logic [NUM_PT-1:0]   xsrc_o,
    output logic [NUM_PT-1:0]   ctrl_o
);

    logic [NUM_PT-1:0] sum_vec;

    for (genvar t = 0; t < NUM_PT; t++) begin : g_term
        alloc_t al;
        assign al         = decode_route(route_e'(route_cfg_i[2*t +: 2]));
        assign sum_vec[t] = terms_i[t] & al.to_sum;
        assign xsrc_o[t]  = terms_i[t] & al.to_xor;
        assign ctrl_o[t]  = terms_i[t] & al.to_ctrl;
    end

    assign sum_o = |sum_vec;

    // R3
    sum_needs_term_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        sum_o |-> (terms_i != '0));

    // R6
    ctrl_excl_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones(ctrl_o & xsrc_o) == 0);

endmodule

// File: rtl/pterm_xor_stage.sv
module pterm_xor_stage
    import pterm_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              local_sum_i,
    input  logic              casc_i,
    input  logic [1:0]        xmode_i,
    input  logic [IDX_W-1:0]  xidx_i,
    input  logic [NUM_PT-1:0] xsrc_i,
    output logic              casc_o,
    output logic              xor_o
);

    logic picked;
    logic second;

    always_comb begin
        picked = 1'b0;
        for (int i = 0; i < NUM_PT; i++) begin
            if (xidx_i == IDX_W'(i)) picked = xsrc_i[i];
        end
    end

    always_comb begin
        case (xsel_e'(xmode_i))
            XS_ONE:  second = 1'b1;
            XS_TERM: second = picked;
            default: second = 1'b0;
        endcase
    end

    assign casc_o = local_sum_i | casc_i;
    assign xor_o  = casc_o ^ second;

    // R4
    casc_pass_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        casc_i |-> casc_o);

    // R5
    xor_invert_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (xmode_i == 2'b01) |-> (xor_o != casc_o));

    // R5
    xor_plain_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (xmode_i[1] == xmode_i[0]) |-> (xor_o == casc_o));

    // R8
    xor_idx_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ((xmode_i == 2'b10) && (xidx_i >= IDX_W'(NUM_PT))) |-> (xor_o == casc_o));

endmodule

// File: rtl/pterm_cell.sv
module pterm_cell
    import pterm_pkg::*;
#(
    parameter int BUS_W = 40
) (
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  logic [BUS_W-1:0]           bus_i,
    input  logic [NUM_PT*2*BUS_W-1:0]  lit_cfg_i,
    input  logic [2*NUM_PT-1:0]        route_cfg_i,
    input  logic [1:0]                 xmode_i,
    input  logic [IDX_W-1:0]           xidx_i,
    input  logic [IDX_W-1:0]           fold_idx_i,
    input  logic                       casc_i,
    output logic                       casc_o,
    output logic                       xor_o,
    output logic [NUM_PT-1:0]          ctrl_o,
    output logic                       fold_o
);

    localparam int LIT_W = 2 * BUS_W;

    logic [NUM_PT-1:0] pt_vec;
    logic [NUM_PT-1:0] xsrc_vec;
    logic              local_sum;
    logic              fold_pick;

    for (genvar t = 0; t < NUM_PT; t++) begin : g_pt
        pterm_and #(.BUS_W(BUS_W)) u_and (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .bus_i  (bus_i),
            .lit_i  (lit_cfg_i[t*LIT_W +: LIT_W]),
            .term_o (pt_vec[t])
        );
    end

    pterm_route u_route (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .terms_i     (pt_vec),
        .route_cfg_i (route_cfg_i),
        .sum_o       (local_sum),
        .xsrc_o      (xsrc_vec),
        .ctrl_o      (ctrl_o)
    );

    pterm_xor_stage u_xor (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .local_sum_i (local_sum),
        .casc_i      (casc_i),
        .xmode_i     (xmode_i),
        .xidx_i      (xidx_i),
        .xsrc_i      (xsrc_vec),
        .casc_o      (casc_o),
        .xor_o       (xor_o)
    );

    always_comb begin
        fold_pick = 1'b0;
        for (int i = 0; i < NUM_PT; i++) begin
            if (fold_idx_i == IDX_W'(i)) fold_pick = pt_vec[i];
        end
    end

    assign fold_o = ~fold_pick;

    // R7
    fold_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (fold_idx_i >= IDX_W'(NUM_PT)) |-> fold_o);

    // R6
    ctrl_has_term_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (ctrl_o & ~pt_vec) == '0);

    // R4
    casc_from_sum_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!casc_i && casc_o) |-> (pt_vec != '0));

endmodule

// File: tb/pterm_cell_tb_top.sv
`timescale 1ns/1ps
module pterm_cell_tb_top;

    localparam int W   = 8;
    localparam int NPT = 5;
    localparam int LW  = NPT * 2 * W;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [W-1:0]   bus;
    logic [LW-1:0]  lit;
    logic [9:0]     route;
    logic [1:0]     xmode;
    logic [2:0]     xidx;
    logic [2:0]     fidx;
    logic           cin;
    logic           casc_o, xor_o, fold_o;
    logic [NPT-1:0] ctrl_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    pterm_cell #(.BUS_W(W)) dut_i (
        .clk_i(clk), .rst_i(rst), .bus_i(bus), .lit_cfg_i(lit),
        .route_cfg_i(route), .xmode_i(xmode), .xidx_i(xidx),
        .fold_idx_i(fidx), .casc_i(cin), .casc_o(casc_o),
        .xor_o(xor_o), .ctrl_o(ctrl_o), .fold_o(fold_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural reference built from the requirement text
    task automatic compare_model(input string tag);
        int pt[NPT];
        int sum, cas, sec, xo, fo, ctl;
        for (int t = 0; t < NPT; t++) begin
            pt[t] = 1;
            for (int b = 0; b < W; b++) begin
                int code;
                code = int'(lit[(t*W+b)*2 +: 2]);
                if (code == 1 && bus[b] == 1'b0) pt[t] = 0;
                if (code == 2 && bus[b] == 1'b1) pt[t] = 0;
                if (code == 3) pt[t] = 0;
            end
        end
        sum = 0;
        ctl = 0;
        for (int t = 0; t < NPT; t++) begin
            int r;
            r = int'(route[2*t +: 2]);
            if (r == 0 && pt[t] == 1) sum = 1;
            if (r == 2 && pt[t] == 1) ctl += (1 << t);
        end
        cas = sum | int'(cin);
        sec = 0;
        if (xmode == 2'd1) sec = 1;
        if (xmode == 2'd2 && xidx < 3'd5) begin
            if (int'(route[2*xidx +: 2]) == 1) sec = pt[xidx];
        end
        xo = cas ^ sec;
        fo = (fidx < 3'd5) ? 1 - pt[fidx] : 1;
        chk({tag, " R4 casc_o"}, int'(casc_o), cas);
        chk({tag, " R5 xor_o"},  int'(xor_o),  xo);
        chk({tag, " R6 ctrl_o"}, int'(ctrl_o), ctl);
        chk({tag, " R7 fold_o"}, int'(fold_o), fo);
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    function automatic logic [LW-1:0] one_lit(input int t, input int b, input logic [1:0] c);
        logic [LW-1:0] v;
        v = '0;
        v[(t*W+b)*2 +: 2] = c;
        return v;
    endfunction

    initial begin
        #(4 * 200000);
        chk("watchdog", 1, 0);
        done = 1;
    end

    initial begin
        bus = '0; lit = '0; route = '0; xmode = '0;
        xidx = '0; fidx = '0; cin = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        // Reset state: all-DC terms routed to the sum
        chk("R2 reset casc_o", int'(casc_o), 1);
        chk("R2 reset xor_o",  int'(xor_o),  1);
        chk("R6 reset ctrl_o", int'(ctrl_o), 0);
        chk("R7 reset fold_o", int'(fold_o), 0);
        @(negedge clk);
        rst = 1'b0;

        // R1: single true literal on term 0, other terms unused
        route = 10'b11_11_11_11_00;
        lit   = one_lit(0, 3, 2'b01);
        bus   = 8'h08; settle();
        chk("R1 pos match", int'(casc_o), 1);
        bus   = 8'hF7; settle();
        chk("R1 pos miss", int'(casc_o), 0);
        lit   = one_lit(0, 5, 2'b10);
        bus   = 8'h00; settle();
        chk("R1 neg match", int'(casc_o), 1);
        lit   = one_lit(0, 5, 2'b11);
        settle();
        chk("R1 kill", int'(casc_o), 0);
        compare_model("R1");

        // R3: a true term routed to XOR stays out of the sum
        lit   = '0;
        route = 10'b11_11_11_11_01;
        xmode = 2'b00; settle();
        chk("R3 xor-routed term not in sum", int'(casc_o), 0);
        xmode = 2'b10; xidx = 3'd0; settle();
        chk("R5 term mode", int'(xor_o), 1);
        // R8: out-of-range index
        xidx  = 3'd6; settle();
        chk("R8 idx out of range", int'(xor_o), 0);
        // R8: indexed term not routed to XOR
        route = 10'b11_11_11_11_10; xidx = 3'd0; settle();
        chk("R8 not xor-routed", int'(xor_o), 0);
        chk("R6 ctrl term", int'(ctrl_o), 1);
        // R4 cascade in
        cin   = 1'b1; xmode = 2'b01; settle();
        chk("R4 casc in", int'(casc_o), 1);
        chk("R5 invert", int'(xor_o), 0);
        fidx  = 3'd7; settle();
        chk("R7 fold range", int'(fold_o), 1);
        compare_model("R8");

        // Random patterns compared every clock
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            for (int k = 0; k < NPT * W; k++) begin
                int r;
                r = $urandom_range(0, 15);
                lit[2*k +: 2] = (r < 11) ? 2'b00 : (r < 13) ? 2'b01 :
                                (r < 15) ? 2'b10 : 2'b11;
            end
            bus   = W'($urandom);
            route = 10'($urandom);
            xmode = 2'($urandom);
            xidx  = 3'($urandom);
            fidx  = 3'($urandom);
            cin   = ($urandom_range(0, 3) == 0);
            #1;
            compare_model("rand");
        end

        done = 1;
    end

    initial begin
        wait (done);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule